// File: doc/BRIEF.md
# Shaped Subport Scheduler with Virtual Port Map

This block is the top level of an egress scheduling hierarchy. Thirty-two subports share one outgoing cell link. Each subport has its own programmable rate and is limited to it by a virtual-clock shaper. On every slot strobe the block picks at most one backlogged subport and reports it together with a physical multi-PHY address.

Shaping does not conserve work: a subport whose timestamp is still in the future is not served, even when the link would otherwise go idle. There are two exceptions, each with its own enable bit. The processor capture subport (the highest-numbered one) and one segmentation subport selected by a register can take leftover slots beyond their shaped rate.

The granted subport is passed through a writable translation table. After reset the table is the identity. It can be rewritten so that several subports send their cells to the same physical port address.

Top module: `subport_shaper`

## Requirements
- R1: After reset no grant is signalled, every subport timestamp and the slot clock are zero (so all subports are immediately due), and table entry i holds address i.
- R2: On a slot, a subport is due when it is backlogged and its timestamp is at or before the slot clock. Among due subports the one with the oldest timestamp wins, and ties go to the lowest index.
- R3: When a subport is granted through shaping at slot time t, its timestamp becomes t + N + 1, where N is its 8-bit rate field `rate_i[8*i +: 8]`. The slot clock advances by one on every slot, so the subport is due again N + 1 slots later.
- R4: If no subport is due and no enabled excess port is backlogged, the slot is idle: no grant is issued and no timestamp changes.
- R5: When `cap_xs_en_i` is set, no subport is due, and subport 31 is backlogged, subport 31 is granted.
- R6: When `seg_xs_en_i` is set, no subport is due, and the subport named by `seg_port_i` is backlogged, that subport is granted, unless R5 already grants subport 31.
- R7: A grant through excess service (R5 or R6) leaves the granted subport's timestamp unchanged.
- R8: A table write stores `map_addr_i` at entry `map_idx_i`. Any number of entries may hold the same address. `grant_addr_o` is the entry of the granted subport.
- R9: A table write in the same cycle as a slot strobe does not affect that slot's address. A write in any earlier cycle does.
- R10: `grant_valid_o` is high only in the cycle after a slot strobe that issues a grant. `grant_port_o` and `grant_addr_o` change only in that cycle and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| slot_i | input | 1 | Slot strobe: one scheduling decision |
| backlog_i | input | 32 | Per-subport backlog flags |
| rate_i | input | 256 | Per-subport 8-bit rate field; spacing is field + 1 slots |
| cap_xs_en_i | input | 1 | Enable excess service for subport 31 |
| seg_xs_en_i | input | 1 | Enable excess service for the selected segmentation subport |
| seg_port_i | input | 5 | Index of the segmentation subport |
| map_we_i | input | 1 | Translation table write enable |
| map_idx_i | input | 5 | Table entry to write |
| map_addr_i | input | 5 | Physical address to store |
| grant_valid_o | output | 1 | Grant issued for the previous slot |
| grant_port_o | output | 5 | Granted subport |
| grant_addr_o | output | 5 | Physical address of the granted subport |

## Verification
The hardest case to reach from the ports is one that shows an excess grant left the shaping timestamp alone. Only the grant pattern reveals it, and only after excess service stops. The bench enables capture service and lets subport 31 take a run of excess slots while its shaped interval runs. It then turns excess service off and expects idle slots followed by exactly one shaped grant at the originally scheduled slot. Long randomised sweeps of backlog, rates, enables and segmentation index are run against an arithmetic model of the slot clock and timestamps. Table writes placed on slot cycles exercise the boundary between writes that are too late for a slot and writes that are in time.

// File: rtl/subport_shaper.sv
module subport_shaper #(
  parameter int NPORT = 32,
  parameter int IDXW  = $clog2(NPORT),
  parameter int TSW   = 16,
  parameter int RATEW = 8,
  parameter int AW    = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   slot_i,
  input  logic [NPORT-1:0]       backlog_i,
  input  logic [NPORT*RATEW-1:0] rate_i,
  input  logic                   cap_xs_en_i,
  input  logic                   seg_xs_en_i,
  input  logic [IDXW-1:0]        seg_port_i,
  input  logic                   map_we_i,
  input  logic [IDXW-1:0]        map_idx_i,
  input  logic [AW-1:0]          map_addr_i,
  output logic                   grant_valid_o,
  output logic [IDXW-1:0]        grant_port_o,
  output logic [AW-1:0]          grant_addr_o
);

  localparam logic [TSW-1:0]  AGE_MAX = {1'b0, {(TSW-1){1'b1}}};
  localparam logic [IDXW-1:0] CAP_IDX = IDXW'(NPORT-1);

  logic [TSW-1:0] ts_q [NPORT];
  logic [TSW-1:0] age  [NPORT];
  logic [TSW-1:0] now_q;
  logic [AW-1:0]  map_q [NPORT];

  logic            found;
  logic [IDXW-1:0] best_idx;
  logic [TSW-1:0]  best_age;

  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_age = '0;
    for (int i = 0; i < NPORT; i++) begin
      age[i] = now_q - ts_q[i];
      if (backlog_i[i] && !age[i][TSW-1] && (!found || age[i] > best_age)) begin
        found    = 1'b1;
        best_idx = IDXW'(i);
        best_age = age[i];
      end
    end
  end

  wire            cap_hit   = cap_xs_en_i && backlog_i[NPORT-1];
  wire            seg_hit   = seg_xs_en_i && backlog_i[seg_port_i];
  wire            sel_valid = found || cap_hit || seg_hit;
  wire [IDXW-1:0] sel_idx   = found ? best_idx : (cap_hit ? CAP_IDX : seg_port_i);
  wire [TSW-1:0]  next_ts   = now_q + {{(TSW-RATEW){1'b0}}, rate_i[best_idx*RATEW +: RATEW]} + 1'b1;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      now_q <= '0;
      for (int i = 0; i < NPORT; i++) ts_q[i] <= '0;
    end else if (slot_i) begin
      now_q <= now_q + 1'b1;
      for (int i = 0; i < NPORT; i++) begin
        if (found && best_idx == IDXW'(i))
          ts_q[i] <= next_ts;
        else if (age[i] == AGE_MAX)
          ts_q[i] <= ts_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPORT; i++) map_q[i] <= AW'(i);
    end else if (map_we_i) begin
      map_q[map_idx_i] <= map_addr_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      grant_valid_o <= 1'b0;
      grant_port_o  <= '0;
      grant_addr_o  <= '0;
    end else begin
      grant_valid_o <= slot_i && sel_valid;
      if (slot_i && sel_valid) begin
        grant_port_o <= sel_idx;
        grant_addr_o <= map_q[sel_idx];
      end
    end
  end

endmodule

module subport_shaper_chk #(
  parameter int NPORT = 32,
  parameter int IDXW  = 5,
  parameter int AW    = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             slot_i,
  input logic [NPORT-1:0] backlog_i,
  input logic             cap_xs_en_i,
  input logic             grant_valid_o,
  input logic [IDXW-1:0]  grant_port_o,
  input logic [AW-1:0]    grant_addr_o
);

  logic [NPORT-1:0] bl_q;
  always_ff @(posedge clk_i) bl_q <= backlog_i;

  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i |=> !grant_valid_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i |=> ($stable(grant_port_o) && $stable(grant_addr_o)));

  p_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i && backlog_i == '0) |=> !grant_valid_o);

  p_backlogged_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> bl_q[grant_port_o]);

  p_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i && cap_xs_en_i && backlog_i[NPORT-1]) |=> grant_valid_o);

endmodule

bind subport_shaper subport_shaper_chk #(.NPORT(NPORT), .IDXW(IDXW), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .slot_i(slot_i), .backlog_i(backlog_i),
  .cap_xs_en_i(cap_xs_en_i), .grant_valid_o(grant_valid_o),
  .grant_port_o(grant_port_o), .grant_addr_o(grant_addr_o));

// File: tb/subport_shaper_bench.sv
module subport_shaper_bench;
  localparam int NP = 32;

  logic          clk_i = 0;
  logic          rst_ni = 0;
  logic          slot_i = 0;
  logic [NP-1:0] backlog_i = '0;
  logic [NP*8-1:0] rate_i = '0;
  logic          cap_xs_en_i = 0, seg_xs_en_i = 0;
  logic [4:0]    seg_port_i = '0;
  logic          map_we_i = 0;
  logic [4:0]    map_idx_i = '0, map_addr_i = '0;
  logic          grant_valid_o;
  logic [4:0]    grant_port_o, grant_addr_o;

  subport_shaper u_subport_shaper (.*);

  always #2 clk_i = ~clk_i;

  int tests = 0, fails = 0;
  int ts [NP];
  int mp [NP];
  int now = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_rate(input int p, input int v);
    rate_i[p*8 +: 8] = 8'(v);
  endtask

  task automatic step(input string tag, input bit we, input int widx, input int waddr);
    int w; int ba; bit v; bit shaped; int pp, pa;
    @(negedge clk_i);
    slot_i = 1; map_we_i = we; map_idx_i = 5'(widx); map_addr_i = 5'(waddr);
    w = -1; ba = -1; shaped = 0;
    for (int i = 0; i < NP; i++)
      if (backlog_i[i] && now - ts[i] >= 0 && now - ts[i] > ba) begin w = i; ba = now - ts[i]; end
    if (w >= 0) shaped = 1;
    else if (cap_xs_en_i && backlog_i[NP-1]) w = NP-1;
    else if (seg_xs_en_i && backlog_i[seg_port_i]) w = int'(seg_port_i);
    v = (w >= 0);
    @(negedge clk_i);
    slot_i = 0; map_we_i = 0;
    chk(grant_valid_o == v, tag, grant_valid_o, v);
    if (v) begin
      chk(grant_port_o == 5'(w), tag, grant_port_o, w);
      chk(grant_addr_o == 5'(mp[w]), {tag, " R8"}, grant_addr_o, mp[w]);
    end
    if (shaped) ts[w] = now + int'(rate_i[w*8 +: 8]) + 1;
    now++;
    if (we) mp[widx] = waddr;
    pp = grant_port_o; pa = grant_addr_o;
    @(negedge clk_i);
    chk(grant_valid_o == 0, "R10", grant_valid_o, 0);
    chk(grant_port_o == 5'(pp) && grant_addr_o == 5'(pa), "R10", grant_port_o, pp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) begin ts[i] = 0; mp[i] = i; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(grant_valid_o == 0, "R1", grant_valid_o, 0);

    // R1/R2: all due at zero, tie to lowest index, identity map
    backlog_i = '1;
    for (int k = 0; k < 4; k++) step("R1 R2", 0, 0, 0);

    // R3: single port spacing
    backlog_i = '0; backlog_i[7] = 1; set_rate(7, 3);
    for (int k = 0; k < 12; k++) step("R3", 0, 0, 0);

    // R4: nothing backlogged
    backlog_i = '0;
    for (int k = 0; k < 3; k++) step("R4", 0, 0, 0);

    // R7: excess service leaves timestamp alone
    backlog_i = '0; backlog_i[NP-1] = 1; set_rate(NP-1, 9); cap_xs_en_i = 1;
    for (int k = 0; k < 6; k++) step("R7 R5", 0, 0, 0);
    cap_xs_en_i = 0;
    for (int k = 0; k < 12; k++) step("R7", 0, 0, 0);

    // R2/R3/R4 sweep, no excess
    for (int k = 0; k < 600; k++) begin
      backlog_i = $urandom & $urandom;
      if (k % 50 == 0) for (int i = 0; i < NP; i++) set_rate(i, $urandom % 16);
      step("R2 R3 R4", 0, 0, 0);
    end

    // R5/R6 sweep with excess options
    for (int k = 0; k < 600; k++) begin
      backlog_i = $urandom & $urandom & $urandom;
      cap_xs_en_i = 1'($urandom); seg_xs_en_i = 1'($urandom);
      seg_port_i = 5'($urandom);
      if (k % 40 == 0) for (int i = 0; i < NP; i++) set_rate(i, 20 + $urandom % 40);
      step("R5 R6 R7", 0, 0, 0);
    end

    // R8/R9: many-to-one table, writes with and without slots
    for (int i = 0; i < NP; i++) begin
      @(negedge clk_i);
      map_we_i = 1; map_idx_i = 5'(i); map_addr_i = 5'(i % 4);
      @(negedge clk_i);
      map_we_i = 0; mp[i] = i % 4;
    end
    cap_xs_en_i = 1; seg_xs_en_i = 0;
    backlog_i = '0; backlog_i[NP-1] = 1;
    step("R8", 0, 0, 0);
    step("R9", 1, NP-1, 17);
    step("R9", 0, 0, 0);
    for (int k = 0; k < 300; k++) begin
      backlog_i = $urandom & $urandom;
      cap_xs_en_i = 1'($urandom); seg_xs_en_i = 1'($urandom);
      seg_port_i = 5'($urandom);
      step("R8 R9", 1'($urandom), $urandom % NP, $urandom % 32);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule